// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block is a single-word SPI master in clock mode 0. Its distinguishing feature is control over chip-select timing. A start strobe samples a small configuration set: a 3-bit setup code, a 3-bit hold code, the chip-select polarity, the bit order and the word length. The block then runs a complete word:

- it asserts chip select;
- it waits the setup delay;
- it clocks the bits out on MOSI while capturing MISO;
- it waits the hold delay;
- it releases chip select and pulses `done` with the received word.

All timing is counted in half-bit periods. One half-bit period is `HALF_DIV` system clocks, so delays of 0.5 and 1.5 bit periods are exact. The setup and hold codes are sparse. Setup offers 0, 0.5, 1, 1.5 and 2 bit periods. Hold offers the same values plus 3 bit periods. Any code outside these sets runs as zero delay and latches an error flag that stays set until reset.

Top module: `spi_sync_seq`

## Requirements
- R1: After reset:
  - `syncOut` is at the inactive level for the current polarity input;
  - `sck`, `mosi`, `busy`, `done` and `configErr` are 0.
- R2: The first rising `sck` edge comes (1 + setup) half-bit periods after chip select asserts. Setup code maps to half-bit periods as: 000→0, 001→2, 010→4, 101→1, 110→3.
- R3: Chip select releases `hold` half-bit periods after the final falling `sck` edge. Hold code maps to half-bit periods as: 000→0, 001→2, 010→4, 011→6, 101→1, 110→3.
- R4: Illegal codes run as zero delay. These are setup 011, 100 and 111, and hold 100 and 111. A start that uses one sets `configErr`, and the flag stays 1 until reset.
- R5: Clock mode 0 applies. `sck` idles low and each bit gives one low half-period and then one high half-period. MOSI changes only while `sck` is low. A word gives exactly as many rising edges as its effective length.
- R6: `lsbFirst`=1 sends `txData[0]` first. `lsbFirst`=0 sends bit (length−1) first. Only the low `length` bits of `txData` go out.
- R7: MISO is sampled on each rising `sck` edge. `rxData` holds the received word right-aligned, with the first bit placed at bit 0 (LSB-first) or at bit length−1 (MSB-first). Higher bits are 0.
- R8: The effective word length is `wordLen` clamped to the range 8 to `MAX_BITS`.
- R9: `syncActHigh`=1 makes chip select active-high, and 0 makes it active-low. While idle, `syncOut` follows the inactive level of the input one cycle later.
- R10: `busy` rises the cycle after an accepted start. `done` is a one-cycle pulse in the same cycle that chip select releases and `busy` falls.
- R11: All configuration and `txData` are sampled at the accepted start. A start, or any input change, made while `busy` is 1 has no effect on the word in flight and launches no second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one word when idle |
| setupCode | input | 3 | Chip-select setup delay code |
| holdCode | input | 3 | Chip-select hold delay code |
| syncActHigh | input | 1 | 1: chip select active-high |
| lsbFirst | input | 1 | 1: least significant bit first |
| wordLen | input | LEN_W (6) | Requested bits per word |
| txData | input | MAX_BITS (32) | Word to transmit |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the slave |
| syncOut | output | 1 | Chip select line |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rxData | output | MAX_BITS (32) | Received word, valid with `done` |
| configErr | output | 1 | Sticky illegal-code flag |

## Verification
The bench drives legal setup and hold codes, word lengths from 8 to 32, both bit orders and both polarities with seeded random values. It measures three intervals in system cycles: chip-select assert to first rise, last fall to release, and release to `done`. These measurements catch a design that counts whole instead of half periods, that drops the extra half-period of baseline setup, or that confuses the 3-period hold with an illegal code.

Directed frames cover the remaining corner cases:
- illegal setup codes, which a faulty design would delay by a stray amount or fail to flag;
- lengths below 8 and above the maximum, which would give the wrong number of clock edges;
- a second start and changed inputs in the middle of a word, which a design that latches late would honour, corrupting the word or sending two.

// File: rtl/spi_sync_pkg.sv
package spi_sync_pkg;

  localparam int MIN_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // accept a new word
    logic sample;  // rising sck: capture miso
    logic shift;   // falling sck: present next bit
    logic active;  // word in flight
  } stb_t;

  typedef struct packed {
    logic [2:0] half;  // delay in half-bit periods
    logic       bad;   // illegal code
  } dly_t;

  function automatic dly_t decodeSetup(input logic [2:0] code);
    dly_t r;
    r.bad = 1'b0;
    case (code)
      3'b000:  r.half = 3'd0;
      3'b001:  r.half = 3'd2;
      3'b010:  r.half = 3'd4;
      3'b101:  r.half = 3'd1;
      3'b110:  r.half = 3'd3;
      default: begin r.half = 3'd0; r.bad = 1'b1; end
    endcase
    return r;
  endfunction

  function automatic dly_t decodeHold(input logic [2:0] code);
    dly_t r;
    r.bad = 1'b0;
    case (code)
      3'b000:  r.half = 3'd0;
      3'b001:  r.half = 3'd2;
      3'b010:  r.half = 3'd4;
      3'b011:  r.half = 3'd6;
      3'b101:  r.half = 3'd1;
      3'b110:  r.half = 3'd3;
      default: begin r.half = 3'd0; r.bad = 1'b1; end
    endcase
    return r;
  endfunction

  function automatic int clampLen(input int req, input int maxBits);
    if (req < MIN_BITS) return MIN_BITS;
    if (req > maxBits)  return maxBits;
    return req;
  endfunction

endpackage

// File: rtl/spi_sync_ctrl.sv
module spi_sync_ctrl
  import spi_sync_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int HALF_DIV = 2,
  localparam int LEN_W = $clog2(MAX_BITS + 1),
  localparam int PRE_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       setupCode,
  input  logic [2:0]       holdCode,
  input  logic             syncActHigh,
  input  logic [LEN_W-1:0] lenEff,
  output stb_t             stb,
  output logic             sck,
  output logic             syncOut,
  output logic             busy,
  output logic             done,
  output logic             configErr
);

  seqState_t        state;
  logic [PRE_W-1:0] pre;
  logic [2:0]       cnt;
  logic [LEN_W-1:0] bitCnt;
  logic [LEN_W-1:0] lenReg;
  logic [2:0]       setupHalf;
  logic [2:0]       holdHalf;
  logic             highHalf;
  logic             syncActive;
  logic             polReg;

  dly_t sDec, hDec;
  logic tick, accept, lastBit, finish;

  assign sDec    = decodeSetup(setupCode);
  assign hDec    = decodeHold(holdCode);
  assign tick    = (pre == PRE_W'(HALF_DIV - 1));
  assign accept  = (state == ST_IDLE) && start;
  assign lastBit = (bitCnt == lenReg - 1'b1);
  assign finish  = ((state == ST_SHIFT) && tick && highHalf && lastBit && (holdHalf == 3'd0))
                || ((state == ST_HOLD) && tick && (cnt == holdHalf - 3'd1));

  assign stb.load   = accept;
  assign stb.sample = (state == ST_SHIFT) && tick && !highHalf;
  assign stb.shift  = (state == ST_SHIFT) && tick && highHalf && !lastBit;
  assign stb.active = (state != ST_IDLE);

  assign busy    = (state != ST_IDLE);
  assign syncOut = polReg ? syncActive : ~syncActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pre        <= '0;
      cnt        <= '0;
      bitCnt     <= '0;
      lenReg     <= LEN_W'(MAX_BITS);
      setupHalf  <= '0;
      holdHalf   <= '0;
      highHalf   <= 1'b0;
      sck        <= 1'b0;
      syncActive <= 1'b0;
      polReg     <= 1'b0;
      done       <= 1'b0;
      configErr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE) pre <= tick ? '0 : pre + 1'b1;
      if (finish) begin
        syncActive <= 1'b0;
        done       <= 1'b1;
        state      <= ST_IDLE;
      end
      case (state)
        ST_IDLE: begin
          polReg <= syncActHigh;
          if (start) begin
            setupHalf  <= sDec.half;
            holdHalf   <= hDec.half;
            lenReg     <= lenEff;
            configErr  <= configErr | sDec.bad | hDec.bad;
            syncActive <= 1'b1;
            pre        <= '0;
            cnt        <= '0;
            bitCnt     <= '0;
            highHalf   <= 1'b0;
            state      <= (sDec.half == 3'd0) ? ST_SHIFT : ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            if (cnt == setupHalf - 3'd1) begin
              cnt   <= '0;
              state <= ST_SHIFT;
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!highHalf) begin
              sck      <= 1'b1;
              highHalf <= 1'b1;
            end else begin
              sck      <= 1'b0;
              highHalf <= 1'b0;
              if (lastBit) begin
                cnt <= '0;
                if (holdHalf != 3'd0) state <= ST_HOLD;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        ST_HOLD: begin
          if (tick && !finish) cnt <= cnt + 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: done lasts exactly one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: done coincides with chip-select release
  a_r10_done_release: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!syncActive && $past(syncActive)));

  // R5: clock idles low outside a word
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sck);

  // R11: latched configuration does not move during a word
  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(lenReg) && $stable(setupHalf) && $stable(holdHalf)));

  // R4: error flag is sticky
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !$fell(configErr));

  // R8: bit counter stays inside the word
  a_r8_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (bitCnt < lenReg));

endmodule

// File: rtl/spi_sync_dp.sv
module spi_sync_dp
  import spi_sync_pkg::*;
#(
  parameter int MAX_BITS = 32,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  stb_t                stb,
  input  logic                lsbFirst,
  input  logic [LEN_W-1:0]    lenEff,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rxData
);

  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;
  logic                lsbReg;
  logic [LEN_W-1:0]    lenReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      lsbReg  <= 1'b0;
      lenReg  <= LEN_W'(MAX_BITS);
    end else if (stb.load) begin
      lsbReg  <= lsbFirst;
      lenReg  <= lenEff;
      rxShift <= '0;
      txShift <= lsbFirst ? txData : (txData << (LEN_W'(MAX_BITS) - lenEff));
    end else if (stb.sample) begin
      rxShift <= lsbReg ? {miso, rxShift[MAX_BITS-1:1]} : {rxShift[MAX_BITS-2:0], miso};
    end else if (stb.shift) begin
      txShift <= lsbReg ? (txShift >> 1) : (txShift << 1);
    end
  end

  assign mosi   = stb.active & (lsbReg ? txShift[0] : txShift[MAX_BITS-1]);
  assign rxData = lsbReg ? (rxShift >> (LEN_W'(MAX_BITS) - lenReg)) : rxShift;

  // R6: the first bit on MOSI is the one the bit order selects
  a_r6_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (mosi == $past(lsbFirst ? txData[0] : txData[lenEff - 1'b1])));

endmodule

// File: rtl/spi_sync_seq.sv
module spi_sync_seq
  import spi_sync_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int HALF_DIV = 2,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          setupCode,
  input  logic [2:0]          holdCode,
  input  logic                syncActHigh,
  input  logic                lsbFirst,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic                syncOut,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rxData,
  output logic                configErr
);

  stb_t             stb;
  logic [LEN_W-1:0] lenEff;

  assign lenEff = LEN_W'(clampLen(int'(wordLen), MAX_BITS));

  spi_sync_ctrl #(.MAX_BITS(MAX_BITS), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .setupCode(setupCode),
    .holdCode(holdCode), .syncActHigh(syncActHigh), .lenEff(lenEff),
    .stb(stb), .sck(sck), .syncOut(syncOut), .busy(busy), .done(done),
    .configErr(configErr)
  );

  spi_sync_dp #(.MAX_BITS(MAX_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lsbFirst(lsbFirst), .lenEff(lenEff),
    .txData(txData), .miso(miso), .mosi(mosi), .rxData(rxData)
  );

  // R5: MOSI holds still while sck is high
  a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: tb/spi_sync_seq_tb.sv
module spi_sync_seq_tb;
  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  setupCode = '0, holdCode = '0;
  logic        syncActHigh = 1'b0, lsbFirst = 1'b0;
  logic [5:0]  wordLen = 6'd8;
  logic [31:0] txData = '0;
  logic        miso;
  logic        sck, mosi, syncOut, busy, done, configErr;
  logic [31:0] rxData;

  always #2.5 clk = ~clk;

  spi_sync_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .setupCode(setupCode), .holdCode(holdCode),
    .syncActHigh(syncActHigh), .lsbFirst(lsbFirst), .wordLen(wordLen), .txData(txData),
    .miso(miso), .sck(sck), .mosi(mosi), .syncOut(syncOut), .busy(busy), .done(done),
    .rxData(rxData), .configErr(configErr)
  );

  int nChk = 0, nFail = 0, cyc = 0;
  bit tbPol, tbLsb;
  int effLen;
  logic [31:0] slv;
  int riseCnt, doneCnt, tAssert, tRelease, tFirstRise, tLastFall, tDone;
  logic [31:0] rxSeen;
  bit gotBits [0:63];
  bit prevAct, prevSck;

  function automatic int expSetup(input logic [2:0] c);
    case (c) 3'b001: return 2; 3'b010: return 4; 3'b101: return 1; 3'b110: return 3; default: return 0; endcase
  endfunction
  function automatic int expHold(input logic [2:0] c);
    case (c) 3'b001: return 2; 3'b010: return 4; 3'b011: return 6; 3'b101: return 1; 3'b110: return 3; default: return 0; endcase
  endfunction
  function automatic int clampL(input int l);
    return (l < 8) ? 8 : ((l > 32) ? 32 : l);
  endfunction
  function automatic logic slaveBit(input int i);
    if (i >= effLen) return 1'b0;
    return tbLsb ? slv[i] : slv[effLen - 1 - i];
  endfunction

  assign miso = slaveBit(riseCnt);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nChk++; nFail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  always @(negedge clk) begin
    bit act;
    act = (syncOut == tbPol);
    if (rstN) begin
      if (act && !prevAct) tAssert = cyc;
      if (!act && prevAct) tRelease = cyc;
      if (sck && !prevSck) begin
        if (riseCnt == 0) tFirstRise = cyc;
        if (riseCnt < 64) gotBits[riseCnt] = mosi;
        riseCnt++;
      end
      if (!sck && prevSck) tLastFall = cyc;
      if (done) begin tDone = cyc; doneCnt++; rxSeen = rxData; end
    end
    prevAct = act;
    prevSck = sck;
  end

  task automatic doReset;
    rstN = 1'b0; start = 1'b0; syncActHigh = 1'b0; tbPol = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [2:0] sc, input logic [2:0] hc, input bit pol, input bit lsb,
                          input int len, input logic [31:0] tx, input logic [31:0] sl, input bit poke);
    int es, eh, wd;
    logic [31:0] got, mask;
    es = expSetup(sc); eh = expHold(hc);
    @(negedge clk);
    setupCode = sc; holdCode = hc; syncActHigh = pol; lsbFirst = lsb;
    wordLen = 6'(len); txData = tx;
    tbPol = pol; tbLsb = lsb; effLen = clampL(len); slv = sl;
    repeat (2) @(negedge clk);
    riseCnt = 0; doneCnt = 0; tAssert = -1; tRelease = -1; tFirstRise = -1; tLastFall = -1; tDone = -2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; setupCode = 3'b010; holdCode = 3'b011; lsbFirst = ~lsb;
      wordLen = 6'd20; txData = ~tx; syncActHigh = ~pol;
      @(negedge clk);
      start = 1'b0;
    end
    wd = 0;
    while (doneCnt == 0 && wd < 2000) begin @(negedge clk); wd++; end
    chk(wd < 2000, "R10 done seen", wd, 0);
    setupCode = sc; holdCode = hc; syncActHigh = pol; lsbFirst = lsb; txData = tx;
    mask = (effLen == 32) ? 32'hFFFF_FFFF : ((32'd1 << effLen) - 32'd1);
    got = '0;
    for (int i = 0; i < effLen; i++) begin
      if (lsb) got[i] = gotBits[i]; else got[effLen - 1 - i] = gotBits[i];
    end
    chk(riseCnt == effLen, "R5/R8 sck rising edges", riseCnt, effLen);
    chk(got == (tx & mask), "R6 mosi word", got, tx & mask);
    chk(rxSeen == (sl & mask), "R7 rx word", rxSeen, sl & mask);
    chk(tFirstRise - tAssert == (es + 1) * HD, "R2 setup gap", tFirstRise - tAssert, (es + 1) * HD);
    chk(tRelease - tLastFall == eh * HD, "R3 hold gap", tRelease - tLastFall, eh * HD);
    chk(tDone == tRelease, "R10 done with release", tDone, tRelease);
    repeat (HD * 8) @(negedge clk);
    chk(doneCnt == 1 && busy == 1'b0, poke ? "R11 no second word" : "R10 single done", doneCnt, 1);
  endtask

  logic [2:0] legalS [5] = '{3'b000, 3'b001, 3'b010, 3'b101, 3'b110};
  logic [2:0] legalH [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b101, 3'b110};

  initial begin
    void'($urandom(32'd2024));
    doReset();
    // R1 reset state
    chk(syncOut == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R1 idle pins", {syncOut, sck, mosi}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0 && configErr == 1'b0, "R1 idle flags", {busy, done, configErr}, 0);
    // R9 idle level follows polarity
    syncActHigh = 1'b1; tbPol = 1'b1;
    repeat (2) @(negedge clk);
    chk(syncOut == 1'b0, "R9 idle active-high", syncOut, 0);

    // directed: every legal code at both extremes
    for (int i = 0; i < 5; i++) runFrame(legalS[i], 3'b000, 1'b0, 1'b0, 8, 32'hA5, 32'h3C, 1'b0);
    for (int i = 0; i < 6; i++) runFrame(3'b000, legalH[i], 1'b1, 1'b1, 32, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
    // R8 clamps
    runFrame(3'b101, 3'b110, 1'b0, 1'b1, 3, 32'hFFFF_FF5A, 32'h0000_00C3, 1'b0);
    runFrame(3'b001, 3'b011, 1'b1, 1'b0, 45, 32'h8000_0001, 32'hF0F0_0F0F, 1'b0);
    // random
    for (int k = 0; k < 40; k++) begin
      runFrame(legalS[$urandom_range(4)], legalH[$urandom_range(5)], 1'($urandom), 1'($urandom),
               int'($urandom_range(32, 8)), $urandom, $urandom, 1'b0);
    end
    chk(configErr == 1'b0, "R4 no error on legal codes", configErr, 0);
    // R11 mid-word start and input changes
    runFrame(3'b110, 3'b101, 1'b0, 1'b0, 16, 32'h0000_B00C, 32'h0000_6E21, 1'b1);
    // R4 illegal codes
    runFrame(3'b011, 3'b001, 1'b1, 1'b0, 12, 32'h0000_0ABC, 32'h0000_0555, 1'b0);
    chk(configErr == 1'b1, "R4 error on setup 011", configErr, 1);
    runFrame(3'b100, 3'b111, 1'b0, 1'b1, 9, 32'h0000_01A5, 32'h0000_0133, 1'b0);
    runFrame(3'b001, 3'b001, 1'b0, 1'b0, 10, 32'h0000_0321, 32'h0000_02AA, 1'b0);
    chk(configErr == 1'b1, "R4 error sticky", configErr, 1);
    doReset();
    chk(configErr == 1'b0, "R1/R4 cleared by reset", configErr, 0);
    summary();
  end
endmodule